// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block multiplies or divides two 32-bit integers over many clock cycles and keeps the outcome in two private result registers, a high word and a low word, which sit apart from any general register file. A product puts its upper half in the high word and its lower half in the low word. A quotient goes to the low word and the remainder to the high word. Each arithmetic operation is either signed or unsigned. That choice only changes how the operand bits are read. No overflow is ever flagged; software inspects the high word when it cares.

A requester presents an operation code and two operands with `req_valid`. A request is taken in a cycle where `req_ready` is high. An arithmetic request starts a one-bit-per-cycle iteration: a shift-add loop for products and a restoring loop for quotients. Both loops work on operand magnitudes, and signs are restored in a final cycle. The two move-out codes return the high or low word on `rd_data` one cycle after acceptance. While an operation runs, `req_ready` is low, so a move-out request is held off until the new result is in place.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 1 (unsigned multiply) leaves the upper 32 bits of the 64-bit unsigned product in the high word and the lower 32 bits in the low word.
- R2: Operation code 0 (signed multiply) leaves the 64-bit two's-complement product of the signed operands split the same way: upper half high, lower half low.
- R3: Operation code 3 (unsigned divide) of `req_a` by a non-zero `req_b` leaves the quotient in the low word and the remainder in the high word, with `req_a` = quotient × `req_b` + remainder.
- R4: Operation code 2 (signed divide) truncates the quotient toward zero, and the remainder carries the sign of `req_a`. The case 0x80000000 / 0xFFFFFFFF yields low word 0x80000000 and high word 0, with no error indication.
- R5: A divide (code 2 or 3) with `req_b` = 0 completes normally, leaving the low word all ones and the high word equal to `req_a`.
- R6: An accepted arithmetic request raises `busy` in the next cycle and holds it for exactly 33 cycles. `req_ready` is low for that whole time, and requests presented meanwhile have no effect.
- R7: Code 4 reads the high word and code 5 the low word. A read is accepted only while `busy` is low. `rd_valid` pulses for one cycle in the cycle after acceptance, with the value on `rd_data`, which otherwise holds its value. A read held during an operation returns that operation's result.
- R8: Codes 6 and 7 are accepted, start nothing and return nothing. `busy` and `rd_valid` stay low, and both result words keep their values.
- R9: After reset `busy` and `rd_valid` are low, `req_ready` is high, and both result words read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0..7) |
| req_a | input | 32 | Multiplicand or dividend |
| req_b | input | 32 | Multiplier or divisor |
| req_ready | output | 1 | Request accepted this cycle if valid |
| busy | output | 1 | Arithmetic operation in progress |
| rd_valid | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | 32 | Word returned by a read |

## Verification
A read of a result word and the end of an arithmetic operation can meet in the same cycle. That cycle is the first one with `busy` low, when the new words have just been written and a waiting read is taken. The bench starts a signed divide and, in the very next cycle, begins holding a read request of the low word, briefly also offering a second divide that must be ignored. The read is judged correct only if it returns the new quotient rather than the stale word, and a following read of the high word must show the first divide's remainder.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S = 3'd0,
        OP_MUL_U = 3'd1,
        OP_DIV_S = 3'd2,
        OP_DIV_U = 3'd3,
        OP_RD_HI = 3'd4,
        OP_RD_LO = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mdu_state_e;

    // Control captured at acceptance, consumed at the fix-up cycle
    typedef struct packed {
        logic is_div;    // quotient/remainder rather than product
        logic neg_main;  // negate product or quotient
        logic neg_rem;   // negate remainder (dividend was negative)
        logic div_zero;  // divisor was zero
    } mdu_ctl_t;

    function automatic logic op_is_arith(mdu_op_e op);
        return (op == OP_MUL_S) || (op == OP_MUL_U) ||
               (op == OP_DIV_S) || (op == OP_DIV_U);
    endfunction

    function automatic logic op_is_div(mdu_op_e op);
        return (op == OP_DIV_S) || (op == OP_DIV_U);
    endfunction

    function automatic logic op_is_signed(mdu_op_e op);
        return (op == OP_MUL_S) || (op == OP_DIV_S);
    endfunction

    function automatic logic op_is_read(mdu_op_e op);
        return (op == OP_RD_HI) || (op == OP_RD_LO);
    endfunction

endpackage

// File: rtl/mdu_mul_step.sv
// One shift-add iteration: low half holds the remaining multiplier bits,
// high half accumulates partial sums.
module mdu_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] work_i,
    input  logic [WIDTH-1:0]   mcand_i,
    output logic [2*WIDTH-1:0] work_o
);
    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   acc_sum;

    always_comb begin
        addend  = work_i[0] ? mcand_i : '0;
        acc_sum = {1'b0, work_i[2*WIDTH-1:WIDTH]} + {1'b0, addend};
        work_o  = {acc_sum, work_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/mdu_div_step.sv
// One restoring-division iteration on {remainder, quotient/dividend}.
module mdu_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] work_i,
    input  logic [WIDTH-1:0]   dvsr_i,
    output logic [2*WIDTH-1:0] work_o
);
    logic [WIDTH:0]   shifted;
    logic             fits;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] rem_next;

    always_comb begin
        shifted  = {work_i[2*WIDTH-1:WIDTH], work_i[WIDTH-1]};
        fits     = (shifted >= {1'b0, dvsr_i});
        // When the subtraction fits, the true difference is below the
        // divisor, so the modulo-2^WIDTH difference is exact.
        diff     = shifted[WIDTH-1:0] - dvsr_i;
        rem_next = fits ? diff : shifted[WIDTH-1:0];
        work_o   = {rem_next, work_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/mdu_result_fix.sv
// Restores signs after the magnitude datapath and applies the
// divide-by-zero convention.
module mdu_result_fix
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] work_i,
    input  mdu_ctl_t           ctl_i,
    output logic [WIDTH-1:0]   hi_o,
    output logic [WIDTH-1:0]   lo_o
);
    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0]   quo;
    logic [WIDTH-1:0]   rem;

    always_comb begin
        prod = ctl_i.neg_main ? (~work_i + 1'b1) : work_i;
        quo  = ctl_i.neg_main ? (~work_i[WIDTH-1:0] + 1'b1) : work_i[WIDTH-1:0];
        rem  = ctl_i.neg_rem  ? (~work_i[2*WIDTH-1:WIDTH] + 1'b1)
                              : work_i[2*WIDTH-1:WIDTH];
        if (ctl_i.is_div) begin
            hi_o = rem;
            lo_o = ctl_i.div_zero ? '1 : quo;
        end else begin
            hi_o = prod[2*WIDTH-1:WIDTH];
            lo_o = prod[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [WIDTH-1:0] req_a,
    input  logic [WIDTH-1:0] req_b,
    output logic             req_ready,
    output logic             busy,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    localparam int CW = $clog2(WIDTH);
    localparam int PW = 2 * WIDTH;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mdu_state_e       state_q;
    logic [CW-1:0]    cnt_q;
    logic [PW-1:0]    work_q;
    logic [WIDTH-1:0] opnd_q;
    mdu_ctl_t         ctl_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;

    mdu_op_e          op_in;
    logic             accept;
    logic             neg_a;
    logic             neg_b;
    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    mdu_ctl_t         ctl_in;
    logic [PW-1:0]    work_init;
    logic [WIDTH-1:0] opnd_init;

    logic [PW-1:0]    mul_next;
    logic [PW-1:0]    div_next;
    logic [PW-1:0]    step_next;
    logic [WIDTH-1:0] fix_hi;
    logic [WIDTH-1:0] fix_lo;

    assign op_in     = mdu_op_e'(req_op);
    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Operand preparation: magnitudes plus sign bookkeeping
    always_comb begin
        neg_a  = op_is_signed(op_in) && req_a[WIDTH-1];
        neg_b  = op_is_signed(op_in) && req_b[WIDTH-1];
        mag_a  = neg_a ? (~req_a + 1'b1) : req_a;
        mag_b  = neg_b ? (~req_b + 1'b1) : req_b;
        ctl_in.is_div   = op_is_div(op_in);
        ctl_in.neg_main = neg_a ^ neg_b;
        ctl_in.neg_rem  = neg_a;
        ctl_in.div_zero = (req_b == '0);
        if (op_is_div(op_in)) begin
            work_init = {{WIDTH{1'b0}}, mag_a};
            opnd_init = mag_b;
        end else begin
            work_init = {{WIDTH{1'b0}}, mag_b};
            opnd_init = mag_a;
        end
    end

    mdu_mul_step #(.WIDTH(WIDTH)) u_mul (
        .work_i  (work_q),
        .mcand_i (opnd_q),
        .work_o  (mul_next)
    );

    mdu_div_step #(.WIDTH(WIDTH)) u_div (
        .work_i  (work_q),
        .dvsr_i  (opnd_q),
        .work_o  (div_next)
    );

    assign step_next = ctl_q.is_div ? div_next : mul_next;

    mdu_result_fix #(.WIDTH(WIDTH)) u_fix (
        .work_i (work_q),
        .ctl_i  (ctl_q),
        .hi_o   (fix_hi),
        .lo_o   (fix_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            work_q   <= '0;
            opnd_q   <= '0;
            ctl_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && op_is_arith(op_in)) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        work_q  <= work_init;
                        opnd_q  <= opnd_init;
                        ctl_q   <= ctl_in;
                    end else if (accept && op_is_read(op_in)) begin
                        rd_valid <= 1'b1;
                        rd_data  <= (op_in == OP_RD_HI) ? hi_q : lo_q;
                    end
                end
                ST_RUN: begin
                    work_q <= step_next;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    hi_q    <= fix_hi;
                    lo_q    <= fix_lo;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             req_ready,
    input logic             busy,
    input logic             rd_valid,
    input logic [WIDTH-1:0] rd_data
);
    logic take;
    logic take_arith;
    logic take_read;
    logic take_rsv;
    int unsigned run_len;

    assign take       = req_valid && req_ready;
    assign take_arith = take && (req_op <= 3'd3);
    assign take_read  = take && ((req_op == 3'd4) || (req_op == 3'd5));
    assign take_rsv   = take && (req_op >= 3'd6);

    always_ff @(posedge clk) begin
        if (rst) run_len <= 0;
        else     run_len <= busy ? run_len + 1 : 0;
    end

    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        take_arith |=> busy);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == unsigned'(WIDTH + 1)));

    p_read_resp_r7: assert property (@(posedge clk) disable iff (rst)
        take_read |=> rd_valid);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !take_read |=> !rd_valid);

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !take_read |=> $stable(rd_data));

    p_reserved_idle_r8: assert property (@(posedge clk) disable iff (rst)
        take_rsv |=> (!busy && !rd_valid));
endmodule

bind muldiv_unit mdu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_a = '0;
    logic [31:0] req_b = '0;
    logic        req_ready;
    logic        busy;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    muldiv_unit #(.WIDTH(32)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_a(req_a), .req_b(req_b), .req_ready(req_ready), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish act=%0d exp<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference results computed from the requirements
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] hi, output logic [31:0] lo);
        logic signed [63:0] sa, sb, sp, sq, sr;
        logic [63:0] ua, ub, up, uq, ur;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        ua = {32'b0, a};
        ub = {32'b0, b};
        hi = '0;
        lo = '0;
        case (op)
            3'd0: begin sp = sa * sb; hi = sp[63:32]; lo = sp[31:0]; end
            3'd1: begin up = ua * ub; hi = up[63:32]; lo = up[31:0]; end
            3'd2: begin
                if (b == 0) begin hi = a; lo = '1; end
                else begin sq = sa / sb; sr = sa % sb; hi = sr[31:0]; lo = sq[31:0]; end
            end
            3'd3: begin
                if (b == 0) begin hi = a; lo = '1; end
                else begin uq = ua / ub; ur = ua % ub; hi = ur[31:0]; lo = uq[31:0]; end
            end
            default: ;
        endcase
    endtask

    // Hold a read until taken, return what came back
    task automatic do_read(input logic [2:0] op, output logic vld, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        vld  = rd_valid;
        data = rd_data;
    endtask

    task automatic read_both(input string tag, input logic [31:0] exp_hi, input logic [31:0] exp_lo);
        logic v;
        logic [31:0] d;
        do_read(3'd4, v, d);
        check32({tag, " rd_valid(R7)"}, {31'b0, v}, 32'd1);
        check32({tag, " hi"}, d, exp_hi);
        do_read(3'd5, v, d);
        check32({tag, " lo"}, d, exp_lo);
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        req_valid = 1'b1;
        req_op = op;
        req_a  = a;
        req_b  = b;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] eh, el;
        model(op, a, b, eh, el);
        issue(op, a, b);
        while (busy) @(negedge clk);
        read_both(tag, eh, el);
    endtask

    task automatic test_reset();
        logic v;
        logic [31:0] d;
        check32("R9 busy", {31'b0, busy}, 32'd0);
        check32("R9 req_ready", {31'b0, req_ready}, 32'd1);
        check32("R9 rd_valid", {31'b0, rd_valid}, 32'd0);
        do_read(3'd4, v, d);
        check32("R9 hi", d, 32'd0);
        do_read(3'd5, v, d);
        check32("R9 lo", d, 32'd0);
    endtask

    task automatic test_busy_len();
        int n;
        issue(3'd1, 32'd1234, 32'd5678);
        n = 0;
        while (busy) begin
            n++;
            if (req_ready) check32("R6 ready low while busy", 32'd1, 32'd0);
            @(negedge clk);
        end
        check32("R6 busy cycles", n, 32'd33);
    endtask

    // Read held across the completion cycle, plus an ignored request
    task automatic test_overlap();
        logic v;
        logic [31:0] d, eh, el;
        model(3'd2, 32'hFFFFFF9C, 32'd7, eh, el);
        issue(3'd2, 32'hFFFFFF9C, 32'd7);
        check32("R6 busy after start", {31'b0, busy}, 32'd1);
        req_valid = 1'b1;
        req_op = 3'd3;
        req_a = 32'd1000;
        req_b = 32'd3;
        repeat (3) @(negedge clk);
        do_read(3'd5, v, d);
        check32("R7 held read valid", {31'b0, v}, 32'd1);
        check32("R7 held read gets new lo", d, el);
        check32("R6 busy done after read", {31'b0, busy}, 32'd0);
        do_read(3'd4, v, d);
        check32("R6 ignored request kept hi", d, eh);
    endtask

    task automatic test_reserved();
        logic [31:0] eh, el;
        model(3'd3, 32'd100, 32'd9, eh, el);
        run_case("R3 pre", 3'd3, 32'd100, 32'd9);
        for (int c = 6; c < 8; c++) begin
            issue(3'(c), 32'hDEAD0000, 32'h0000BEEF);
            check32("R8 busy stays low", {31'b0, busy}, 32'd0);
            check32("R8 no rd_valid", {31'b0, rd_valid}, 32'd0);
            read_both("R8 words kept", eh, el);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_case("R1 8x9", 3'd1, 32'd8, 32'd9);
        run_case("R1 max", 3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run_case("R2 neg*pos", 3'd0, 32'hFFFFFFFD, 32'd7);
        run_case("R2 min*min", 3'd0, 32'h80000000, 32'h80000000);
        run_case("R2 neg*neg", 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run_case("R3 74/8", 3'd3, 32'd74, 32'd8);
        run_case("R3 max/3", 3'd3, 32'hFFFFFFFF, 32'd3);
        run_case("R4 -7/2", 3'd2, 32'hFFFFFFF9, 32'd2);
        run_case("R4 7/-2", 3'd2, 32'd7, 32'hFFFFFFFE);
        run_case("R4 -7/-2", 3'd2, 32'hFFFFFFF9, 32'hFFFFFFFE);
        run_case("R4 min/-1", 3'd2, 32'h80000000, 32'hFFFFFFFF);
        run_case("R5 u 123/0", 3'd3, 32'd123, 32'd0);
        run_case("R5 s -5/0", 3'd2, 32'hFFFFFFFB, 32'd0);
        test_busy_len();
        test_overlap();
        test_reserved();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule